// File: doc/BRIEF.md
# Multi-Window Address Decoder with Translation

This block holds up to six address windows and decides which of them, if any, claims an incoming 32-bit bus address. Each window has a base, a mask and a translation value, all covering address bits 31:8. It also has a space flag that selects memory or IO, a translate-enable bit and a prefetch-enable bit. The lowest-numbered matching window wins. When that window has translation enabled, the masked upper address bits are replaced by its translation value. The block reports a hit flag, the winning window index and the resulting address. Address bits 7:0 are never decoded and always pass through unchanged.

Window 0 can be built as a fixed 4 KB configuration window. In that form only its base is writable; its mask, translation value, space flag and control bits are constants. Windows can be left out of a build. An absent window reads as zero and never claims an address. A synchronous write port programs the windows. A combinational read port returns the programmed values. The decode is combinational, and a parameter can add one output register stage after it.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every writable window field reads as zero. With the output stage built, `hit`=0, `hit_idx`=0 and `xlat_addr`=0 until the first request is registered.
- R2: A write with `wr_en`=1 takes effect at the rising clock edge. `wr_sel` selects the field: 0 is the base (data bits 31:8, plus bit 0 as the space flag), 1 is the mask (bits 31:8), 2 is the translation value (bits 31:8), and 3 is control (bit 1 enables translation, bit 2 enables prefetch). The read port returns each field in the same bit positions, with all other bits at zero.
- R3: A window claims a request when its mask is nonzero and (addr[31:8] & mask) equals (base & mask).
- R4: A window claims a request only when `req_io` equals its space flag (0 means memory, 1 means IO). The configuration window is always memory space.
- R5: On a hit with translation enabled, xlat_addr[31:8] = (trans & mask) | (addr[31:8] & ~mask). On a miss, or on a hit with translation disabled, xlat_addr equals req_addr. Bits 7:0 always pass through.
- R6: When several windows claim a request, the lowest index wins. On a miss, `hit_idx` is 0.
- R7: With `CFG_WIN0`=1, window 0 reads its mask as 0xFFFFF000 and its translation value and control as 0. Its space flag is fixed at memory. Writes to any of these are ignored.
- R8: A window absent from the build, and any window select of 6 or 7, reads as zero, never hits and ignores writes.
- R9: With `OUT_REG`=1, the outputs show the decode of the request that was present at the previous rising edge. With `OUT_REG`=0, they follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 3 | Window written |
| wr_sel | input | 2 | Field written (R2 encoding) |
| wr_data | input | 32 | Write data |
| rd_win | input | 3 | Window read |
| rd_sel | input | 2 | Field read |
| rd_data | output | 32 | Read data |
| req_addr | input | 32 | Address to decode |
| req_io | input | 1 | Request space: 0 memory, 1 IO |
| hit | output | 1 | Some window claims the request |
| hit_idx | output | 3 | Winning window index |
| xlat_addr | output | 32 | Resulting address |

## Verification
A corrupted base, mask or space flag shows up at the next request that falls near the window's edge: `hit` and `hit_idx` change, and the response appears one cycle after the request when the output stage is built. A corrupted translation value or enable shows only in `xlat_addr[31:8]` on a hit. A broken priority shows only when two windows overlap. The bench therefore programs overlapping windows, windows with translation on and off, a zero mask, requests on both sides of window boundaries, and requests of both space types. The read port exposes each field directly, so a write that lands in the wrong place is visible in the same cycle it is read.

// File: rtl/addr_window_pkg.sv
package addr_window_pkg;
    localparam int MAX_WIN = 6;
    localparam int ADDR_W  = 32;
    localparam int LOW_W   = 8;
    localparam int UP_W    = ADDR_W - LOW_W;
    localparam int IDX_W   = 3;
    localparam logic [UP_W-1:0] CFG_MASK = 24'hFFFFF0;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_XLAT = 2'd2,
        SEL_CTRL = 2'd3
    } field_sel_e;

    typedef struct packed {
        logic [UP_W-1:0] base;
        logic            io;
        logic [UP_W-1:0] mask;
        logic [UP_W-1:0] xlat;
        logic            xl_en;
        logic            pf_en;
    } win_cfg_t;
endpackage

// File: rtl/window_regs.sv
module window_regs
    import addr_window_pkg::*;
#(
    parameter bit PRESENT   = 1'b1,
    parameter bit FIXED_CFG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  field_sel_e        sel,
    input  logic [ADDR_W-1:0] wdata,
    output win_cfg_t          cfg
);
    generate
        if (!PRESENT) begin : g_absent
            assign cfg = '0;
        end else if (FIXED_CFG) begin : g_cfg
            logic [UP_W-1:0] base_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    base_q <= '0;
                else if (we && sel == SEL_BASE)
                    base_q <= wdata[ADDR_W-1:LOW_W];
            end
            assign cfg = '{base: base_q, io: 1'b0, mask: CFG_MASK,
                           xlat: '0, xl_en: 1'b0, pf_en: 1'b0};
        end else begin : g_full
            win_cfg_t cfg_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_q <= '0;
                end else if (we) begin
                    unique case (sel)
                        SEL_BASE: begin
                            cfg_q.base <= wdata[ADDR_W-1:LOW_W];
                            cfg_q.io   <= wdata[0];
                        end
                        SEL_MASK: cfg_q.mask <= wdata[ADDR_W-1:LOW_W];
                        SEL_XLAT: cfg_q.xlat <= wdata[ADDR_W-1:LOW_W];
                        SEL_CTRL: begin
                            cfg_q.xl_en <= wdata[1];
                            cfg_q.pf_en <= wdata[2];
                        end
                    endcase
                end
            end
            assign cfg = cfg_q;
        end
    endgenerate
endmodule

// File: rtl/window_match.sv
module window_match
    import addr_window_pkg::*;
(
    input  win_cfg_t        cfg,
    input  logic [UP_W-1:0] addr_up,
    input  logic            req_io,
    output logic            hit,
    output logic [UP_W-1:0] xl_up
);
    logic same_space;
    logic base_eq;

    assign same_space = (cfg.io == req_io);
    assign base_eq    = ((addr_up & cfg.mask) == (cfg.base & cfg.mask));
    assign hit        = (|cfg.mask) && same_space && base_eq;
    assign xl_up      = cfg.xl_en ? ((cfg.xlat & cfg.mask) | (addr_up & ~cfg.mask))
                                  : addr_up;
endmodule

// File: rtl/window_prio.sv
module window_prio
    import addr_window_pkg::*;
#(
    parameter int N = MAX_WIN
) (
    input  logic [N-1:0]     hit_vec,
    input  logic [UP_W-1:0]  xl_up [N],
    input  logic [UP_W-1:0]  dflt_up,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx,
    output logic [UP_W-1:0]  sel_up
);
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        sel_up  = dflt_up;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
                sel_up  = xl_up[i];
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import addr_window_pkg::*;
#(
    parameter int               NUM_WIN     = MAX_WIN,
    parameter logic [MAX_WIN-1:0] WIN_PRESENT = 6'b000111,
    parameter bit               CFG_WIN0    = 1'b1,
    parameter bit               OUT_REG     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_win,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_win,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [ADDR_W-1:0] xlat_addr
);
    localparam logic [MAX_WIN:0]   LIMIT7      = (7'd1 << NUM_WIN) - 7'd1;
    localparam logic [MAX_WIN-1:0] PRESENT_EFF = (WIN_PRESENT | 6'b000011) & LIMIT7[MAX_WIN-1:0];

    win_cfg_t            cfg   [MAX_WIN];
    logic [UP_W-1:0]     xl_up [MAX_WIN];
    logic [MAX_WIN-1:0]  hit_vec;
    logic                d_hit;
    logic [IDX_W-1:0]    d_idx;
    logic [UP_W-1:0]     d_up;

    generate
        for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
            window_regs #(
                .PRESENT   (PRESENT_EFF[g]),
                .FIXED_CFG (g == 0 && CFG_WIN0)
            ) u_regs (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_en && wr_win == IDX_W'(g)),
                .sel   (field_sel_e'(wr_sel)),
                .wdata (wr_data),
                .cfg   (cfg[g])
            );
            window_match u_match (
                .cfg     (cfg[g]),
                .addr_up (req_addr[ADDR_W-1:LOW_W]),
                .req_io  (req_io),
                .hit     (hit_vec[g]),
                .xl_up   (xl_up[g])
            );
        end
    endgenerate

    window_prio #(.N(MAX_WIN)) u_prio (
        .hit_vec (hit_vec),
        .xl_up   (xl_up),
        .dflt_up (req_addr[ADDR_W-1:LOW_W]),
        .any_hit (d_hit),
        .win_idx (d_idx),
        .sel_up  (d_up)
    );

    generate
        if (OUT_REG) begin : g_oreg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hit       <= 1'b0;
                    hit_idx   <= '0;
                    xlat_addr <= '0;
                end else begin
                    hit       <= d_hit;
                    hit_idx   <= d_idx;
                    xlat_addr <= {d_up, req_addr[LOW_W-1:0]};
                end
            end
        end else begin : g_comb
            assign hit       = d_hit;
            assign hit_idx   = d_idx;
            assign xlat_addr = {d_up, req_addr[LOW_W-1:0]};
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < MAX_WIN; i++) begin
            if (rd_win == IDX_W'(i)) begin
                unique case (field_sel_e'(rd_sel))
                    SEL_BASE: rd_data = {cfg[i].base, 7'b0, cfg[i].io};
                    SEL_MASK: rd_data = {cfg[i].mask, 8'b0};
                    SEL_XLAT: rd_data = {cfg[i].xlat, 8'b0};
                    SEL_CTRL: rd_data = {29'b0, cfg[i].pf_en, cfg[i].xl_en, 1'b0};
                endcase
            end
        end
    end
endmodule

// File: rtl/addr_window_checker.sv
module addr_window_checker
    import addr_window_pkg::*;
#(
    parameter logic [MAX_WIN-1:0] PRESENT  = 6'b000111,
    parameter bit                 CFG_WIN0 = 1'b1,
    parameter bit                 OUT_REG  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_io,
    input logic              hit,
    input logic [IDX_W-1:0]  hit_idx,
    input logic [ADDR_W-1:0] xlat_addr,
    input logic [IDX_W-1:0]  rd_win,
    input logic [1:0]        rd_sel,
    input logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] al_addr;
    logic              al_io;
    logic              idx_present;

    generate
        if (OUT_REG) begin : g_d
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    al_addr <= '0;
                    al_io   <= 1'b0;
                end else begin
                    al_addr <= req_addr;
                    al_io   <= req_io;
                end
            end
        end else begin : g_n
            assign al_addr = req_addr;
            assign al_io   = req_io;
        end
    endgenerate

    always_comb begin
        idx_present = 1'b0;
        for (int i = 0; i < MAX_WIN; i++)
            if (hit_idx == IDX_W'(i)) idx_present = PRESENT[i];
    end

    a_r6_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_idx == '0);
    a_r8_absent_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> idx_present);
    a_r5_low_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> xlat_addr[LOW_W-1:0] == al_addr[LOW_W-1:0]);
    a_r5_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> xlat_addr == al_addr);
    a_r4_cfg_memory_only: assert property (@(posedge clk) disable iff (!rst_n)
        (CFG_WIN0 && hit && hit_idx == '0) |-> !al_io);
    a_r7_cfg_mask_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (CFG_WIN0 && rd_win == '0 && rd_sel == 2'd1) |-> rd_data == 32'hFFFFF000);
endmodule

bind addr_window_decoder addr_window_checker #(
    .PRESENT  (PRESENT_EFF),
    .CFG_WIN0 (CFG_WIN0),
    .OUT_REG  (OUT_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_addr  (req_addr),
    .req_io    (req_io),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .xlat_addr (xlat_addr),
    .rd_win    (rd_win),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;
    localparam logic [5:0] PRES = 6'b000111;
    localparam bit         CFG  = 1'b1;
    localparam bit         OREG = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_win = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_win = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic        hit;
    logic [2:0]  hit_idx;
    logic [31:0] xlat_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic        hit;
        logic [2:0]  idx;
        logic [31:0] addr;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [23:0] sh_base [6];
    logic        sh_io   [6];
    logic [23:0] sh_mask [6];
    logic [23:0] sh_xlat [6];
    logic        sh_xl   [6];
    logic        sh_pf   [6];

    always #10 clk = ~clk;

    addr_window_decoder #(
        .NUM_WIN(6), .WIN_PRESENT(PRES), .CFG_WIN0(CFG), .OUT_REG(OREG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_win(rd_win), .rd_sel(rd_sel), .rd_data(rd_data),
        .req_addr(req_addr), .req_io(req_io), .hit(hit), .hit_idx(hit_idx),
        .xlat_addr(xlat_addr)
    );

    function automatic bit pres(input int w);
        return (w < 6) && PRES[w];
    endfunction

    function automatic exp_t model(input logic [31:0] a, input logic io, input string tag);
        exp_t e;
        e.hit = 1'b0; e.idx = '0; e.addr = a; e.tag = tag;
        for (int i = 5; i >= 0; i--) begin
            if (pres(i) && sh_mask[i] != 0 && sh_io[i] == io &&
                ((a[31:8] & sh_mask[i]) == (sh_base[i] & sh_mask[i]))) begin
                e.hit = 1'b1;
                e.idx = 3'(i);
                e.addr = sh_xl[i] ? {(sh_xlat[i] & sh_mask[i]) | (a[31:8] & ~sh_mask[i]), a[7:0]} : a;
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] rd_model(input int w, input int s);
        if (!pres(w)) return '0;
        case (s)
            0: return {sh_base[w], 7'b0, sh_io[w]};
            1: return {sh_mask[w], 8'b0};
            2: return {sh_xlat[w], 8'b0};
            default: return {29'b0, sh_pf[w], sh_xl[w], 1'b0};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int w, input int s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_win = 3'(w); wr_sel = 2'(s); wr_data = d;
        if (pres(w)) begin
            if (w == 0 && CFG) begin
                if (s == 0) sh_base[0] = d[31:8];
            end else begin
                case (s)
                    0: begin sh_base[w] = d[31:8]; sh_io[w] = d[0]; end
                    1: sh_mask[w] = d[31:8];
                    2: sh_xlat[w] = d[31:8];
                    default: begin sh_xl[w] = d[1]; sh_pf[w] = d[2]; end
                endcase
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int w, input int s, input string tag);
        @(negedge clk);
        rd_win = 3'(w); rd_sel = 2'(s);
        #1 check(tag, rd_data, rd_model(w, s));
    endtask

    task automatic send(input logic [31:0] a, input logic io, input string tag);
        @(negedge clk);
        wr_en = 1'b0; req_addr = a; req_io = io;
        q.push_back(model(a, io, tag));
    endtask

    // Monitor: compares each result one edge after its request was driven
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hit !== e.hit || hit_idx !== e.idx || xlat_addr !== e.addr) begin
                errors++;
                $display("FAIL %s: actual hit=%b idx=%0d addr=%h expected hit=%b idx=%0d addr=%h",
                         e.tag, hit, hit_idx, xlat_addr, e.hit, e.idx, e.addr);
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            sh_base[i] = '0; sh_io[i] = 1'b0; sh_mask[i] = '0;
            sh_xlat[i] = '0; sh_xl[i] = 1'b0; sh_pf[i] = 1'b0;
        end
        if (CFG) sh_mask[0] = 24'hFFFFF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 hit", {31'b0, hit}, 32'h0);
        check("R1 idx", {29'b0, hit_idx}, 32'h0);
        check("R1 xlat", xlat_addr, 32'h0);
        rd_check(1, 1, "R1 win1 mask");
        rd_check(2, 0, "R1 win2 base");

        // R7: fixed configuration window
        rd_check(0, 1, "R7 cfg mask");
        wr(0, 1, 32'h12345600);
        rd_check(0, 1, "R7 cfg mask write ignored");
        wr(0, 2, 32'hABCD0000);
        rd_check(0, 2, "R7 cfg xlat write ignored");
        wr(0, 3, 32'h6);
        rd_check(0, 3, "R7 cfg ctrl write ignored");
        wr(0, 0, 32'h10000001);
        rd_check(0, 0, "R7 cfg base, space flag fixed");
        send(32'h10000ABC, 1'b0, "R3 cfg window hit");
        send(32'h10001000, 1'b0, "R3 just above 4KB miss");
        send(32'h10000ABC, 1'b1, "R4 IO request misses cfg window");

        // R2, R5: IO window with translation
        wr(1, 0, 32'h20000001);
        wr(1, 1, 32'hFFFF0000);
        wr(1, 2, 32'h80000000);
        wr(1, 3, 32'h2);
        rd_check(1, 0, "R2 win1 base");
        rd_check(1, 3, "R2 win1 ctrl");
        send(32'h20001234, 1'b1, "R5 translate IO hit");
        send(32'h20001234, 1'b0, "R4 memory request misses IO window");

        // R6: overlap, lowest index wins
        wr(2, 0, 32'h10000000);
        wr(2, 1, 32'hFF000000);
        wr(2, 2, 32'h55000000);
        wr(2, 3, 32'h6);
        rd_check(2, 3, "R2 win2 ctrl prefetch+translate");
        send(32'h10000010, 1'b0, "R6 overlap lowest wins");
        send(32'h10ABCDEF, 1'b0, "R5 win2 translate");
        wr(2, 3, 32'h4);
        send(32'h10ABCDEF, 1'b0, "R5 translate disabled passthrough");
        wr(2, 1, 32'h0);
        send(32'h10ABCDEF, 1'b0, "R3 zero mask never hits");

        // R8: absent window and out-of-range select
        wr(3, 0, 32'h70000000);
        wr(3, 1, 32'hFF000000);
        rd_check(3, 0, "R8 absent base reads zero");
        rd_check(3, 1, "R8 absent mask reads zero");
        send(32'h70000001, 1'b0, "R8 absent window no hit");
        wr(7, 1, 32'hFFFFFF00);
        rd_check(7, 1, "R8 select 7 reads zero");
        send(32'h7FFFFF00, 1'b0, "R8 select 7 write no hit");

        // R9: latency and back-to-back stream
        send(32'h20004321, 1'b1, "R9 stream a");
        #1 check("R9 output held before edge", xlat_addr, 32'h7FFFFF00);
        send(32'h10000F00, 1'b0, "R9 stream b");
        send(32'h33333333, 1'b0, "R9 stream c");
        @(negedge clk);
        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule